// File: doc/BRIEF.md
# Flat Four-Phase Sequencer Stage

One stage of a cyclic, token-passing controller built from four-phase (return-to-zero) request/acknowledge handshakes. Each stage has three handshake pairs: an input pair from the previous step, a work pair to the unit that performs this step's action, and an output pair to the next step. A request on the input pair starts the work. The input is acknowledged early, as soon as the work is acknowledged. The request to the next step is issued at a point chosen by the `MODE` parameter. The stage is modelled as clocked logic: every output is a flop that reacts to input levels sampled on the previous rising clock edge.

Stages are chained head to tail into rings of two or more steps. The output request of one stage is the input request of the next, and the input acknowledge of the next stage is the output acknowledge of this one. Such a ring forms the top-level loop of a state machine. No stage in the loop is in charge. The stage is meant for this flat top level only. Its early acknowledge means that it cannot stand for a nested sequence whose completion must be reported upward.

Three release points are offered. In broad release (`MODE`=0), the next step is requested only after the work and input handshakes have both returned to zero. In weak-broad release (`MODE`=1), the next step is requested once the work request has dropped. In narrow release (`MODE`=2), the next step is requested together with the input acknowledge. The earlier points let the next step overlap the return-to-zero phases of this one.

Top module: `flat_seq_stage`

## Requirements
- R1: While `mclr` is high, `in_ack`, `work_req` and `out_req` are low. The clear takes effect at once, without waiting for a clock edge.
- R2: `work_req` rises on the edge after a cycle in which `in_req` is high and the stage is idle. Idle means that `in_ack`, `work_req` and `out_req` are low and no release is pending. For `MODE` 1 and 2, `out_ack` must also be low in that cycle. For `MODE` 0, `out_ack` is not looked at.
- R3: `work_req` falls on the edge after a cycle in which `work_req` and `work_ack` are both high.
- R4: `in_ack` rises on that same edge, after `work_req` and `work_ack` are seen high together. A release then becomes pending. This input acknowledge comes before the output handshake.
- R5: `in_ack` stays high while `in_req` is high. It falls on the edge after a cycle in which `in_ack` is high and `in_req`, `work_req` and `work_ack` are all low.
- R6: For `MODE` 0, `out_req` rises on the edge after a cycle in which a release is pending and `in_ack`, `work_req`, `work_ack` and `out_ack` are all low.
- R7: For `MODE` 1, `out_req` rises on the edge after a cycle in which a release is pending and `work_req` and `out_ack` are low.
- R8: For `MODE` 2, `out_req` rises on the same edge as `in_ack` if `out_ack` is low in the acknowledging cycle. Otherwise it rises on the edge after the first later cycle in which `out_ack` is low.
- R9: `out_req` falls on the edge after a cycle in which `out_req` and `out_ack` are both high. `out_req` never rises directly after a cycle in which `out_ack` was high.
- R10: In a ring of stages of a single mode, started by one request to stage 0, the token keeps going round. In `MODE` 0, at most one stage in the ring has `work_req` high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| mclr | input | 1 | Active-high asynchronous master clear |
| in_req | input | 1 | Request from the previous step |
| in_ack | output | 1 | Acknowledge to the previous step |
| work_req | output | 1 | Request to this step's work unit |
| work_ack | input | 1 | Completion from the work unit |
| out_req | output | 1 | Request to the next step |
| out_ack | input | 1 | Acknowledge from the next step |

## Verification
In narrow release, the input acknowledge and the output request can rise on the same edge. In broad release, the next stage's work can begin in the same cycle that this stage drops its output request. The bench provokes both by running a three-stage ring in each mode, with random work-unit delays on both edges of the work acknowledge. Because the next stage's acknowledge waits on that stage's own work, the output acknowledge is randomly slow as well. A cycle-by-cycle phase model of every stage predicts all three outputs, so an output that moves one cycle early or late, or in the wrong mode, is reported. The bench also counts laps of the token and checks that only one work request is active in broad mode.

// File: rtl/flat_seq_stage.sv
`timescale 1ns/1ps
module flat_seq_stage #(
  parameter int MODE = 0
) (
  input  logic clk,
  input  logic mclr,
  input  logic in_req,
  output logic in_ack,
  output logic work_req,
  input  logic work_ack,
  output logic out_req,
  input  logic out_ack
);

  localparam bit BROAD  = (MODE == 0);
  localparam bit WEAK   = (MODE == 1);

  logic pend;
  logic rel;

  wire fire    = work_req && work_ack;
  wire idle    = !in_ack && !work_req && !pend && !out_req;
  wire start   = in_req && idle && (BROAD || !out_ack);
  wire ia_done = in_ack && !in_req && !work_req && !work_ack;
  wire or_set  = rel && !out_ack;

  always_comb begin
    if (BROAD)     rel = pend && !in_ack && !work_req && !work_ack;
    else if (WEAK) rel = pend && !work_req;
    else           rel = fire || pend;
  end

  always_ff @(posedge clk or posedge mclr) begin
    if (mclr) begin
      work_req <= 1'b0;
      in_ack   <= 1'b0;
      pend     <= 1'b0;
      out_req  <= 1'b0;
    end else begin
      if (start)     work_req <= 1'b1;
      else if (fire) work_req <= 1'b0;
      in_ack  <= fire || (in_ack && !ia_done);
      pend    <= (pend || fire) && !or_set;
      out_req <= or_set || (out_req && !out_ack);
    end
  end

endmodule

module flat_seq_stage_chk (
  input logic clk,
  input logic mclr,
  input logic in_req,
  input logic in_ack,
  input logic work_req,
  input logic work_ack,
  input logic out_req,
  input logic out_ack
);

  // R1
  reset_low_chk: assert property (@(posedge clk) mclr |-> (!in_ack && !work_req && !out_req));

  // R2
  wr_cause_chk: assert property (@(posedge clk) disable iff (mclr)
    $rose(work_req) |-> $past(in_req));

  // R3
  wr_drop_chk: assert property (@(posedge clk) disable iff (mclr)
    (work_req && work_ack) |=> !work_req);

  // R4
  ia_rise_chk: assert property (@(posedge clk) disable iff (mclr)
    (work_req && work_ack) |=> in_ack);

  // R5
  ia_hold_chk: assert property (@(posedge clk) disable iff (mclr)
    (in_ack && in_req) |=> in_ack);

  // R5
  ia_fall_chk: assert property (@(posedge clk) disable iff (mclr)
    (in_ack && !in_req && !work_req && !work_ack) |=> !in_ack);

  // R9
  or_drop_chk: assert property (@(posedge clk) disable iff (mclr)
    (out_req && out_ack) |=> !out_req);

  // R9
  or_gate_chk: assert property (@(posedge clk) disable iff (mclr)
    $rose(out_req) |-> !$past(out_ack));

endmodule

bind flat_seq_stage flat_seq_stage_chk u_chk (.*);

// File: tb/sim_flat_seq_stage.sv
`timescale 1ns/1ps
module sim_flat_seq_stage;
  localparam int NS = 3;
  localparam int NM = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mclr = 1'b1;
  logic go = 1'b0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int md, input int st, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode %0d stage %0d: got %b expected %b", tag, md, st, act, exp);
    end
  endtask

  for (genvar m = 0; m < NM; m++) begin : gm
    logic [NS-1:0] wr_v, ia_v, or_v, ir_v, oa_v;
    logic kick = 1'b0;
    logic kicked = 1'b0;
    logic or_prev = 1'b0;
    int laps = 0;

    for (genvar s = 0; s < NS; s++) begin : gs
      logic wr, ia, orq;
      logic wa = 1'b0;
      int cnt = 0;
      int in_ph = 0;
      int out_ph = 0;

      if (s == 0) begin : g_head
        assign ir_v[s] = or_v[NS-1] | kick;
      end else begin : g_body
        assign ir_v[s] = or_v[s-1];
      end
      assign oa_v[s] = ia_v[(s+1)%NS];
      assign wr_v[s] = wr;
      assign ia_v[s] = ia;
      assign or_v[s] = orq;

      flat_seq_stage #(.MODE(m)) u0 (
        .clk(clk), .mclr(mclr),
        .in_req(ir_v[s]), .in_ack(ia),
        .work_req(wr), .work_ack(wa),
        .out_req(orq), .out_ack(oa_v[s])
      );

      always @(negedge clk) begin
        if (mclr) begin
          wa = 1'b0;
          cnt = 0;
        end else if (wr != wa) begin
          if (cnt == 0) begin
            wa = wr;
            cnt = $urandom_range(0, 3 + s);
          end else cnt--;
        end
      end

      always @(posedge clk) begin
        int ni, no;
        if (mclr) begin
          in_ph = 0;
          out_ph = 0;
        end else begin
          ni = in_ph;
          no = out_ph;
          case (in_ph)
            0: if (ir_v[s] && out_ph == 0 && (m == 0 || !oa_v[s])) ni = 1;
            1: if (wa) begin
                 ni = 2;
                 no = (m == 2 && !oa_v[s]) ? 2 : 1;
               end
            default: if (!ir_v[s] && !wa) ni = 0;
          endcase
          if (out_ph == 1) begin
            if (!oa_v[s] && ((m == 0 && in_ph == 0 && !wa) || (m == 1 && in_ph != 1) || m == 2))
              no = 2;
          end else if (out_ph == 2 && oa_v[s]) no = 0;
          in_ph = ni;
          out_ph = no;
        end
      end

      always @(negedge clk) begin
        if (!mclr && go) begin
          chk("R2 R3 work request", m, s, wr, in_ph == 1);
          chk("R4 R5 input acknowledge", m, s, ia, in_ph == 2);
          chk(m == 0 ? "R6 R9 output request" : (m == 1 ? "R7 R9 output request" : "R8 R9 output request"),
              m, s, orq, out_ph == 2);
        end
      end
    end

    always @(negedge clk) begin
      if (mclr) begin
        kick = 1'b0;
        kicked = 1'b0;
      end else if (go && !kicked) begin
        kick = 1'b1;
        kicked = 1'b1;
      end else if (kick && ia_v[0]) kick = 1'b0;
      if (or_v[0] && !or_prev) laps++;
      or_prev = or_v[0];
      if (m == 0 && !mclr && go) chk("R10 single active work", m, -1, $countones(wr_v) <= 1, 1'b1);
    end
  end

  task automatic all_low(input string tag);
    chk(tag, 0, -1, |{gm[0].wr_v, gm[0].ia_v, gm[0].or_v}, 1'b0);
    chk(tag, 1, -1, |{gm[1].wr_v, gm[1].ia_v, gm[1].or_v}, 1'b0);
    chk(tag, 2, -1, |{gm[2].wr_v, gm[2].ia_v, gm[2].or_v}, 1'b0);
  endtask

  task automatic lap_check(input int min_laps);
    chk("R10 token circulates", 0, 0, gm[0].laps >= min_laps, 1'b1);
    chk("R10 token circulates", 1, 0, gm[1].laps >= min_laps, 1'b1);
    chk("R10 token circulates", 2, 0, gm[2].laps >= min_laps, 1'b1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    all_low("R1 reset state");
    #2 mclr = 1'b0;
    go = 1'b1;
    repeat (8000) @(negedge clk);
    lap_check(50);
    @(posedge clk);
    #3 mclr = 1'b1;
    #1 all_low("R1 asynchronous clear");
    repeat (2) @(negedge clk);
    all_low("R1 clear held");
    #2 mclr = 1'b0;
    repeat (8000) @(negedge clk);
    lap_check(100);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule